// File: doc/BRIEF.md
# Infrared Carrier Cycle Counter

This block measures the carrier of a modulated infrared signal. It counts rising edges of the raw receive input, but only while a separate envelope input reports a mark, that is a burst of carrier. Software reads the 16-bit count through a byte-wide register port. It divides the count by the total mark time, which is measured elsewhere, to estimate the carrier frequency.

A measurement starts with two writes to the control register. The first sets the clear bit with enable low, and the second sets enable with clear low. The counter stops at all-ones instead of wrapping. Software treats a reading of zero or of all-ones as no usable measurement. The same control register carries a transmit-invert bit that is passed out to the transmit path, and the counter logic never alters it. Reading the high count byte also captures the low byte, so reading high then low gives one coherent 16-bit value.

Top module: `ir_carrier_counter`

## Requirements
- R1: After reset the control register reads 0x00, both count bytes read 0x00 and `tx_invert` is 0.
- R2: The control register sits at offset 1. Bit 0 is enable, bit 1 is clear and bit 2 is transmit-invert. A write stores bits 2:0, and bits 7:3 always read 0. `tx_invert` follows the stored bit 2.
- R3: While enable is 1, clear is 0 and the envelope shows a mark, each rising edge of the carrier input adds exactly one to the count.
- R4: Carrier edges that arrive while the envelope input is low are not counted.
- R5: While enable is 0 and clear is 0, the count holds its value.
- R6: While clear is 1 the count is zero, whatever the state of enable.
- R7: The count saturates at 0xFFFF: further edges leave it at 0xFFFF.
- R8: A read of offset 3 returns count bits 15:8 and captures count bits 7:0 in the same cycle. A read of offset 2 returns that captured byte, even if counting has gone on since.
- R9: Counting, clearing and saturation never change the transmit-invert bit. It changes only when software writes the control register.
- R10: Writes to offsets 0, 2 and 3 have no effect on the count.
- R11: A write of 0x02 followed by a write of 0x01 restarts the measurement from zero, and later edges count up from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_carrier | input | 1 | Raw receive input carrying the carrier, asynchronous |
| ir_mark | input | 1 | Receive envelope, high during a mark, asynchronous |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; a read of offset 3 captures the low byte |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tx_invert | output | 1 | Transmit-invert bit of the control register |

## Verification
The assertions assume that the envelope changes only while the carrier is low. They also assume that each carrier level is held for at least one full clock cycle, so that every input edge reaches the synchronised side as one edge. The stimulus raises and lowers the mark only between carrier bursts. Its fastest carrier is one cycle high and one cycle low, which is the densest pattern the edge detector can resolve. Register strobes last one cycle and change on the falling clock edge, away from the capture edge.

// File: rtl/ir_cnt_pkg.sv
// Package: register offsets, control bit layout and widths shared by the
// carrier counter modules. Assumes a byte-wide register port.
package ir_cnt_pkg;
    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 8;
    localparam int CTRL_W  = 3;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_LO   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_HI   = 3'd3;

    // Control register fields; bit positions are visible to software.
    typedef struct packed {
        logic inv;   // bit 2
        logic clr;   // bit 1
        logic en;    // bit 0
    } ctrl_t;
endpackage

// File: rtl/ir_cnt_sync.sv
// Multi-bit, multi-stage synchroniser for independent asynchronous levels.
// Assumes each bit is a slow level; no bus coherency is provided.
module ir_cnt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One register stage of the chain, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= d_async;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/ir_cnt_core.sv
// Edge detector and saturating carrier counter. Assumes synchronised inputs;
// counts a carrier rising edge only while mark, enable are high and clear low.
module ir_cnt_core
    import ir_cnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carrier_s,
    input  logic             mark_s,
    input  logic             en,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic prev_q;
    logic rise;

    // Remember the previous carrier level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= carrier_s;
    end

    assign rise = carrier_s & ~prev_q;

    // Saturating count of qualified rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (en && mark_s && rise && (count != CNT_MAX))
            count <= count + 1'b1;
    end

    // R3: at most one step per cycle while not clearing
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count)) || (count == $past(count) + 1'b1));

    // R4: no counting without a mark
    assert_no_mark_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mark_s && !clr) |=> $stable(count));

    // R5: hold while disabled
    assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(count));

    // R6: clear forces zero
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R7: no wrap past all-ones
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !clr) |=> (count == CNT_MAX));
endmodule

// File: rtl/ir_cnt_regs.sv
// Byte register port: control register, live high byte and a low byte captured
// on each high-byte read. Assumes one-cycle strobes; read data is combinational.
module ir_cnt_regs
    import ir_cnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  count,
    output logic              en,
    output logic              clr,
    output logic              tx_inv
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] lo_hold_q;
    logic              ctrl_wr;
    logic              hi_rd;
    logic              unused_wbits;

    assign ctrl_wr      = wr && (addr == ADR_CTRL);
    assign hi_rd        = rd && (addr == ADR_HI);
    assign unused_wbits = ^wdata[DATA_W-1:CTRL_W];

    // Control register: only a software write changes it.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Capture the low count byte when the high byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_hold_q <= '0;
        else if (hi_rd) lo_hold_q <= count[DATA_W-1:0];
    end

    // Read multiplexer.
    always_comb begin
        unique case (addr)
            ADR_CTRL: rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            ADR_LO:   rdata = lo_hold_q;
            ADR_HI:   rdata = count[CNT_W-1:DATA_W];
            default:  rdata = '0;
        endcase
    end

    assign en     = ctrl_q.en;
    assign clr    = ctrl_q.clr;
    assign tx_inv = ctrl_q.inv;

    // R9: invert bit moves only on a control write
    assert_inv_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(tx_inv));

    // R8: captured low byte stays put between high-byte reads
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_rd |=> $stable(lo_hold_q));

    // R2: a control write lands its low three bits
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ({tx_inv, clr, en} == $past(wdata[CTRL_W-1:0])));
endmodule

// File: rtl/ir_carrier_counter.sv
// Top level: synchronises carrier and envelope, counts qualified carrier
// edges and exposes the count and control through a byte register port.
module ir_carrier_counter
    import ir_cnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_carrier,
    input  logic              ir_mark,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_invert
);
    logic [1:0]       sync_q;
    logic [CNT_W-1:0] count;
    logic             en;
    logic             clr;

    ir_cnt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ir_mark, ir_carrier}),
        .q_sync  (sync_q)
    );

    ir_cnt_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .carrier_s (sync_q[0]),
        .mark_s    (sync_q[1]),
        .en        (en),
        .clr       (clr),
        .count     (count)
    );

    ir_cnt_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .rd     (reg_rd),
        .rdata  (reg_rdata),
        .count  (count),
        .en     (en),
        .clr    (clr),
        .tx_inv (tx_invert)
    );
endmodule

// File: tb/ir_carrier_counter_bench.sv
module ir_carrier_counter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_carrier = 1'b0;
    logic       ir_mark = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       tx_invert;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    ir_carrier_counter u_ir_carrier_counter (
        .clk(clk), .rst_n(rst_n), .ir_carrier(ir_carrier), .ir_mark(ir_mark),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .tx_invert(tx_invert)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 180000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: got=%0d expected=<=180000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        total = total + 1;
        if (got !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: got=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_count(output int v);
        logic [7:0] hi, lo;
        rd_reg(3'd3, hi);
        rd_reg(3'd2, lo);
        v = {hi, lo};
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            ir_carrier = 1'b1;
            repeat (hi) @(negedge clk);
            ir_carrier = 1'b0;
            repeat (lo) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic restart();
        wr_reg(3'd1, 8'h02);
        wr_reg(3'd1, 8'h01);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd_reg(3'd1, d); check("R1 ctrl", d, 8'h00);
        rd_reg(3'd3, d); check("R1 hi", d, 8'h00);
        rd_reg(3'd2, d); check("R1 lo", d, 8'h00);
        check("R1 tx_invert", tx_invert, 0);
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        wr_reg(3'd1, 8'hFF);
        rd_reg(3'd1, d); check("R2 ctrl readback", d, 8'h07);
        check("R2 tx_invert", tx_invert, 1);
        wr_reg(3'd1, 8'h00);
        check("R2 tx_invert off", tx_invert, 0);
    endtask

    task automatic t_count();
        int v;
        restart();
        ir_mark = 1'b1;
        repeat (4) @(negedge clk);
        pulses(10, 1, 1);
        rd_count(v); check("R3 R11 fast pulses", v, 10);
        pulses(37, 3, 2);
        rd_count(v); check("R3 slow pulses", v, 47);
    endtask

    task automatic t_mark();
        int v;
        ir_mark = 1'b0;
        repeat (4) @(negedge clk);
        pulses(20, 2, 2);
        rd_count(v); check("R4 no mark", v, 47);
    endtask

    task automatic t_disable();
        int v;
        wr_reg(3'd1, 8'h00);
        ir_mark = 1'b1;
        repeat (4) @(negedge clk);
        pulses(15, 1, 1);
        rd_count(v); check("R5 disabled", v, 47);
    endtask

    task automatic t_clear();
        int v;
        wr_reg(3'd1, 8'h03);
        pulses(8, 1, 1);
        rd_count(v); check("R6 clear with enable", v, 0);
        wr_reg(3'd1, 8'h02);
        rd_count(v); check("R6 clear held", v, 0);
        wr_reg(3'd1, 8'h01);
        pulses(5, 1, 1);
        rd_count(v); check("R11 count from zero", v, 5);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        int v;
        pulses(300, 1, 1);
        rd_reg(3'd3, d); check("R8 high byte", d, 8'h01);
        pulses(10, 1, 1);
        rd_reg(3'd2, d); check("R8 captured low", d, 8'h31);
        rd_count(v); check("R8 fresh pair", v, 16'h013B);
    endtask

    task automatic t_ignore();
        int v;
        wr_reg(3'd2, 8'hAA);
        wr_reg(3'd3, 8'hAA);
        wr_reg(3'd0, 8'hAA);
        rd_count(v); check("R10 writes ignored", v, 16'h013B);
    endtask

    task automatic t_txinv();
        logic [7:0] d;
        wr_reg(3'd1, 8'h05);
        pulses(20, 1, 1);
        check("R9 tx_invert kept", tx_invert, 1);
        rd_reg(3'd1, d); check("R9 ctrl kept", d, 8'h05);
    endtask

    task automatic t_sat();
        int v;
        restart();
        pulses(65540, 1, 1);
        rd_count(v); check("R7 saturated", v, 16'hFFFF);
        pulses(3, 1, 1);
        rd_count(v); check("R7 stays saturated", v, 16'hFFFF);
        wr_reg(3'd1, 8'h05);
        pulses(2, 1, 1);
        check("R9 invert after saturation", tx_invert, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_count();
        t_mark();
        t_disable();
        t_clear();
        t_latch();
        t_ignore();
        t_txinv();
        t_sat();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule